// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable integer for the feedback path of a frequency synthesizer. A prescaler counts either eight or nine input clocks per output step. A main counter counts prescaler steps, and a swallow counter decides how many of those steps use the longer nine-clock length. Across one divide cycle the total is M×8+A input clocks, where M is the main count and A is the swallow count. One output pulse marks the end of each divide cycle. The fast clock is modelled as the block's only synchronous clock.

The 11-bit modulus word can change at any time. The block samples it only when a divide cycle ends, so every output period matches exactly one word. The scheme is only meaningful when A ≤ M. A word with a larger swallow count, or with a main count of zero, raises an error flag. The divider then runs with the main count forced up to at least one and the swallow count clamped down to the main count.

Top module: `pswallow_fbdiv`

## Requirements
- R1: The main count M is taken from modulus bits [10:3] and the swallow count A from bits [2:0].
- R2: For a word with 1 ≤ M and A ≤ M, the spacing between consecutive output pulses is exactly M×8+A input clocks.
- R3: With A = 0, the spacing is exactly 8×M clocks, with no swallowed clock.
- R4: The output pulse is high for exactly one clock cycle, and that cycle is the last clock of the divide cycle.
- R5: During reset the output pulse is low. The counters load from the current word, so the first pulse is high in the (M×8+A)-th cycle after reset is released, counting the first cycle after the last reset edge as cycle 1.
- R6: A word that changes partway through a divide cycle has no effect on that cycle's length. It takes effect from the next divide cycle.
- R7: A word with A > M (and M ≥ 1) sets the error flag and divides by M×8+M.
- R8: A word with M = 0 sets the error flag, is treated as M = 1 with A clamped to at most 1, and divides by 8 or 9.
- R9: The error flag describes the word that governs the current divide cycle. It changes only at a reset or at a cycle boundary, so a legal word clears it from its own cycle onwards.
- R10: The extremes 8 (M=1, A=0) and 2047 (M=255, A=7) produce periods of exactly 8 and 2047 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| mod_word | input | 11 | Modulus word: main count in [10:3], swallow count in [2:0] |
| div_pulse | output | 1 | One-cycle pulse on the last clock of each divide cycle |
| cfg_err | output | 1 | High while the governing word has A > M or M = 0 |

## Verification
The assertions assume that reset is held for at least one clock before the first check. They also assume that the modulus word is a plain level sampled on the clock, so any value, legal or not, is valid input. The invariants they check are two: the swallow count left never exceeds the main count left, and no pulse spacing falls outside 8 to 2047. These follow from the clamping alone, whatever the input. The stimulus changes the word only on falling clock edges. It mixes directed words at the legal boundaries and illegal corners with random words drawn from a fixed seed, some of which have A > M or M = 0 on purpose. Main counts are kept small in the random words so that many periods fit in the run.

// File: rtl/pswallow_fbdiv.sv
module pswallow_fbdiv #(
  parameter int MOD_W = 11,
  parameter int SW_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MOD_W-1:0] mod_word,
  output logic             div_pulse,
  output logic             cfg_err
);
  localparam int MAIN_W = MOD_W - SW_W;
  localparam int PRE_N  = 1 << SW_W;
  localparam int PRE_W  = SW_W + 1;
  localparam int PAD_W  = MAIN_W - SW_W;

  logic [MAIN_W-1:0] m_raw, m_eff, m_left;
  logic [SW_W-1:0]   a_raw, a_eff, a_left, a_next;
  logic [PRE_W-1:0]  pre_cnt;
  logic              pre_wrap, reload, bad;

  // R1: field split of the modulus word
  assign m_raw = mod_word[MOD_W-1:SW_W];
  assign a_raw = mod_word[SW_W-1:0];

  // R7, R8: legalise the word
  assign m_eff = (m_raw == '0) ? MAIN_W'(1) : m_raw;
  assign a_eff = ({{PAD_W{1'b0}}, a_raw} > m_eff) ? m_eff[SW_W-1:0] : a_raw;
  assign bad   = (m_raw == '0) || ({{PAD_W{1'b0}}, a_raw} > m_raw);

  assign pre_wrap  = (pre_cnt == '0);
  assign reload    = pre_wrap && (m_left == MAIN_W'(1));
  assign div_pulse = reload;
  assign a_next    = (a_left != '0) ? a_left - SW_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      m_left  <= m_eff;
      a_left  <= a_eff;
      pre_cnt <= (a_eff != '0) ? PRE_W'(PRE_N) : PRE_W'(PRE_N - 1);
      cfg_err <= bad;
    end else if (pre_wrap) begin
      m_left  <= m_left - MAIN_W'(1);
      a_left  <= a_next;
      pre_cnt <= (a_next != '0) ? PRE_W'(PRE_N) : PRE_W'(PRE_N - 1);
    end else begin
      pre_cnt <= pre_cnt - PRE_W'(1);
    end
  end
endmodule

// File: rtl/pswallow_fbdiv_chk.sv
module pswallow_fbdiv_chk #(
  parameter int MOD_W = 11,
  parameter int SW_W  = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  div_pulse,
  input logic                  cfg_err,
  input logic [MOD_W-SW_W-1:0] m_left,
  input logic [SW_W-1:0]       a_left,
  input logic [SW_W:0]         pre_cnt
);
  localparam int MAIN_W = MOD_W - SW_W;
  localparam int MIN_P  = 1 << SW_W;
  localparam int MAX_P  = (1 << MOD_W) - 1;

  logic [MOD_W:0] gap;
  always_ff @(posedge clk) begin
    if (rst || div_pulse) gap <= '0;
    else if (gap != '1) gap <= gap + 1'b1;
  end

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  assert_period_bounds_R2: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> (gap >= (MOD_W+1)'(MIN_P - 1) && gap <= (MOD_W+1)'(MAX_P - 1)));

  assert_err_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !div_pulse |=> $stable(cfg_err));

  assert_swallow_le_main_R7: assert property (@(posedge clk) disable iff (rst)
    MAIN_W'(a_left) <= m_left);

  assert_main_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    m_left != '0);

  assert_presc_range_R3: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= (SW_W+1)'(MIN_P));
endmodule

bind pswallow_fbdiv pswallow_fbdiv_chk #(.MOD_W(MOD_W), .SW_W(SW_W)) u_chk (
  .clk(clk), .rst(rst), .div_pulse(div_pulse), .cfg_err(cfg_err),
  .m_left(m_left), .a_left(a_left), .pre_cnt(pre_cnt)
);

// File: tb/pswallow_fbdiv_tb.sv
module pswallow_fbdiv_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] mod_word = '0;
  logic        div_pulse, cfg_err;
  int          n_chk = 0, n_bad = 0;
  bit          hung = 1'b0;

  always #4 clk = ~clk;

  pswallow_fbdiv u_dut (.clk(clk), .rst(rst), .mod_word(mod_word),
                        .div_pulse(div_pulse), .cfg_err(cfg_err));

  function automatic int exp_period(input logic [10:0] w);
    int m = int'(w[10:3]);
    int a = int'(w[2:0]);
    if (m == 0) m = 1;
    if (a > m) a = m;
    return m * 8 + a;
  endfunction

  function automatic bit exp_err(input logic [10:0] w);
    return (w[10:3] == 0) || (int'(w[2:0]) > int'(w[10:3]));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts falling edges until one shows the pulse high.
  task automatic wait_pulse(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt > 5000) begin
        hung = 1'b1;
        return;
      end
    end while (!div_pulse);
  endtask

  // Called on a pulse edge: the word set here governs the next period.
  task automatic step(input logic [10:0] w, input string req);
    int c;
    mod_word = w;
    wait_pulse(c);
    check(req, c, exp_period(w));
    check({req, " err"}, int'(cfg_err), int'(exp_err(w)));
  endtask

  initial begin
    int c;
    logic [10:0] w;
    void'($urandom(32'd1234));
    mod_word = {8'd2, 3'd1};
    repeat (3) @(negedge clk);
    check("R5 reset pulse", int'(div_pulse), 0);
    check("R5 reset err", int'(cfg_err), 0);
    rst = 1'b0;
    wait_pulse(c);
    // The release edge is cycle 1; counted edges follow it.
    check("R5 first pulse", c + 1, 17);
    @(negedge clk);
    check("R4 pulse width", int'(div_pulse), 0);
    wait_pulse(c);
    check("R2 second period", c + 1, 17);

    step({8'd1, 3'd0}, "R10 min 8");
    step({8'd1, 3'd1}, "R2 M1A1");
    step({8'd5, 3'd0}, "R3 A0");
    step({8'd7, 3'd0}, "R1 56");
    step({8'd7, 3'd7}, "R2 63");
    step({8'd255, 3'd7}, "R10 max 2047");
    step({8'd1, 3'd5}, "R7 A>M");
    step({8'd3, 3'd6}, "R7 A>M 3");
    step({8'd0, 3'd3}, "R8 M0 A3");
    step({8'd0, 3'd0}, "R8 M0 A0");
    step({8'd4, 3'd2}, "R9 clear");

    // R6: change partway through a divide cycle
    mod_word = {8'd6, 3'd3};
    repeat (5) @(negedge clk);
    mod_word = {8'd2, 3'd0};
    c = 5;
    begin
      int r;
      wait_pulse(r);
      c += r;
    end
    check("R6 current kept", c, 51);
    wait_pulse(c);
    check("R6 next uses new", c, 16);

    for (int i = 0; i < 40; i++) begin
      w[10:3] = 8'($urandom_range(0, 40));
      w[2:0]  = 3'($urandom_range(0, 7));
      step(w, "R2 random");
    end

    if (hung) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected pulse");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1200000;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
    $finish;
  end
endmodule